// File: doc/BRIEF.md
# Serial Wire Debug Target Responder

This block is the target end of a two-wire serial debug link. It runs on a fast system clock and oversamples the host's serial clock and bidirectional data line. It hunts for a request header, checks its framing and parity, and announces the decoded access to a register-side agent. The agent answers with an acknowledge decision and, for reads, a data word. The responder then serializes the acknowledge and, when required, a 32-bit read word with parity. For writes it collects the host's data word and hands it over only if its parity checks.

The responder sequences the line direction itself. It keeps track of which phases are followed by a turnaround period, based on the request direction and on the acknowledge code it sent. The data line is sampled on rising serial-clock edges. Every change in the driven value or in the output enable follows a falling edge, after a short fixed synchronizer delay.

Top module: `swd_target_responder`

## Requirements
- R1: While reset is high and just after it, `swdio_oe`, `cmd_valid`, `wr_valid` and `wr_perr` are all 0. A reset also clears a set `wr_perr`.
- R2: A header is sampled over 8 rising edges, least significant bit first. Bit 0 is the start bit (1), bit 1 is the port select (`cmd_ap`), bit 2 is the direction (`cmd_rnw`, 1 = read), bits 3 and 4 are address bits 2 and 3 (`cmd_addr[0]`, `cmd_addr[1]`), bit 5 is even parity over bits 1 to 4, bit 6 is the stop bit (0) and bit 7 is the park bit (1). A valid header gives exactly one single-cycle `cmd_valid` pulse, with the decoded fields held on the command outputs.
- R3: A header with wrong parity, a stop bit of 1 or a park bit of 0 produces no `cmd_valid`. The line is left undriven, and the responder goes back to hunting so that a header sent right after it is accepted.
- R4: After the park bit there is one turnaround bit with `swdio_oe` low. On the next three rising edges the acknowledge is driven least significant bit first: OK is 1,0,0, WAIT is 0,1,0 and FAULT is 0,0,1.
- R5: A `resp_valid` pulse is taken only between `cmd_valid` and the rising edge of the turnaround bit. Without one in that window the acknowledge is WAIT. A response code other than 3'b001 (OK) or 3'b010 (WAIT) is sent as FAULT.
- R6: For a read answered OK, the 32 bits of `resp_rdata` follow the acknowledge, least significant first, then their even parity. A released turnaround bit comes next, after which a new header is accepted.
- R7: For a write answered OK, the line is released for one turnaround bit. The host's 32 data bits (least significant first) and parity are then sampled. Correct parity gives a single `wr_valid` pulse with the word on `wr_data`.
- R8: A write whose data parity is wrong gives no `wr_valid` and sets `wr_perr`, which stays set until reset.
- R9: After a WAIT or FAULT acknowledge, the line is released for one turnaround bit and there is no data phase. A header sent right after it is accepted.
- R10: `swdio_oe` is high only during acknowledge and read-data bits, and it changes only after a detected falling edge of `swclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| swclk | input | 1 | Serial clock from the host |
| swdio_in | input | 1 | Data line as seen at the pad |
| swdio_out | output | 1 | Value driven onto the data line |
| swdio_oe | output | 1 | Data line output enable |
| cmd_valid | output | 1 | One-cycle pulse for an accepted header |
| cmd_ap | output | 1 | Port select of the last accepted header |
| cmd_rnw | output | 1 | Direction of the last accepted header, 1 = read |
| cmd_addr | output | 2 | Address bits 3:2 of the last accepted header |
| resp_valid | input | 1 | Agent's decision is present |
| resp_ack | input | 3 | Agent's acknowledge code |
| resp_rdata | input | DW | Read word supplied with the decision |
| wr_valid | output | 1 | One-cycle pulse for a write word with good parity |
| wr_data | output | DW | Last accepted write word |
| wr_perr | output | 1 | Sticky write-data parity error |

## Verification
The state that matters most is the phase tracker. If it is off by one bit or picks the wrong branch after the acknowledge, the host sees it at once on the line. The output enable rises during a turnaround or a write phase, or an acknowledge or data bit lands one edge late. The next header is then lost, so `cmd_valid` stops pulsing within one transaction. A wrong parity or field decode shows up on the command outputs at the pulse, and a wrong write capture shows up on `wr_data` and `wr_perr` right after the write's last bit.

// File: rtl/swd_tgt_pkg.sv
package swd_tgt_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_REQ,
    S_TA_REQ,
    S_ACK,
    S_RD,
    S_TA_ACK,
    S_WR,
    S_TA_RD
  } swd_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // anything the agent gives that is not OK or WAIT becomes FAULT
  function automatic logic [2:0] legal_ack(input logic [2:0] code);
    if (code == ACK_OK || code == ACK_WAIT) return code;
    return ACK_FAULT;
  endfunction

endpackage

// File: rtl/swd_edge_sync.sv
module swd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_clk,
  input  logic line_dat,
  output logic rise,
  output logic fall,
  output logic dat
);

  logic [STAGES-1:0] ck_s;
  logic [STAGES-1:0] dt_s;
  logic              ck_prev;

  // clock and data go through the same number of stages so they stay aligned
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        ck_s[i] <= 1'b0;
        dt_s[i] <= 1'b0;
      end else if (i == 0) begin
        ck_s[i] <= line_clk;
        dt_s[i] <= line_dat;
      end else begin
        ck_s[i] <= ck_s[(i == 0) ? 0 : i-1];
        dt_s[i] <= dt_s[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ck_prev <= 1'b0;
    else     ck_prev <= ck_s[STAGES-1];
  end

  assign rise = ck_s[STAGES-1] & ~ck_prev;
  assign fall = ~ck_s[STAGES-1] & ck_prev;
  assign dat  = dt_s[STAGES-1];

endmodule

// File: rtl/swd_tgt_fsm.sv
module swd_tgt_fsm
  import swd_tgt_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise,
  input  logic            din,
  input  logic            resp_valid,
  input  logic [2:0]      resp_ack,
  input  logic [DW-1:0]   resp_rdata,
  output swd_state_e      st,
  output logic [1:0]      ack_sel,
  output logic            data_last,
  output logic [2:0]      ack_q,
  output logic            rd_bit,
  output logic            rd_par,
  output logic            cmd_valid,
  output logic            cmd_ap,
  output logic            cmd_rnw,
  output logic [1:0]      cmd_addr,
  output logic            wr_valid,
  output logic [DW-1:0]   wr_data,
  output logic            wr_perr
);

  localparam logic [CW-1:0] HDR_LAST  = CW'(7);
  localparam logic [CW-1:0] ACK_LAST  = CW'(2);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW);

  logic [CW-1:0] cnt;
  logic [6:0]    hdr;
  logic [DW-1:0] rd_sh;
  logic [DW-1:0] wd_sh;
  logic          have_resp;
  logic          resp_hit;
  logic          hdr_ok;
  logic          is_ok;

  assign resp_hit  = (st == S_TA_REQ) && resp_valid;
  // hdr holds bits 0..6 in place; park arrives as din on the eighth edge
  assign hdr_ok    = hdr[0] & ~hdr[6] & din & ~(^hdr[5:1]);
  assign is_ok     = (ack_q == ACK_OK);
  assign ack_sel   = cnt[1:0];
  assign data_last = (cnt == DATA_LAST);
  assign rd_bit    = rd_sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HUNT;
      cnt       <= '0;
      hdr       <= '0;
      rd_sh     <= '0;
      rd_par    <= 1'b0;
      wd_sh     <= '0;
      ack_q     <= ACK_WAIT;
      have_resp <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_ap    <= 1'b0;
      cmd_rnw   <= 1'b0;
      cmd_addr  <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      wr_perr   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      if (resp_hit) begin
        have_resp <= 1'b1;
        ack_q     <= legal_ack(resp_ack);
        rd_sh     <= resp_rdata;
        rd_par    <= ^resp_rdata;
      end
      if (rise) begin
        unique case (st)
          S_HUNT: begin
            if (din) begin
              hdr <= {din, hdr[6:1]};
              cnt <= CW'(1);
              st  <= S_REQ;
            end
          end
          S_REQ: begin
            if (cnt == HDR_LAST) begin
              cnt <= '0;
              if (hdr_ok) begin
                cmd_valid <= 1'b1;
                cmd_ap    <= hdr[1];
                cmd_rnw   <= hdr[2];
                cmd_addr  <= {hdr[4], hdr[3]};
                have_resp <= 1'b0;
                st        <= S_TA_REQ;
              end else begin
                st <= S_HUNT;
              end
            end else begin
              hdr <= {din, hdr[6:1]};
              cnt <= cnt + 1'b1;
            end
          end
          S_TA_REQ: begin
            if (!have_resp && !resp_hit) ack_q <= ACK_WAIT;
            cnt <= '0;
            st  <= S_ACK;
          end
          S_ACK: begin
            if (cnt == ACK_LAST) begin
              cnt <= '0;
              st  <= (is_ok && cmd_rnw) ? S_RD : S_TA_ACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RD: begin
            if (data_last) begin
              cnt <= '0;
              st  <= S_TA_RD;
            end else begin
              rd_sh <= rd_sh >> 1;
              cnt   <= cnt + 1'b1;
            end
          end
          S_TA_ACK: begin
            cnt <= '0;
            st  <= (is_ok && !cmd_rnw) ? S_WR : S_HUNT;
          end
          S_WR: begin
            if (data_last) begin
              cnt <= '0;
              st  <= S_HUNT;
              if (din == ^wd_sh) begin
                wr_valid <= 1'b1;
                wr_data  <= wd_sh;
              end else begin
                wr_perr <= 1'b1;
              end
            end else begin
              wd_sh <= {din, wd_sh[DW-1:1]};
              cnt   <= cnt + 1'b1;
            end
          end
          S_TA_RD: begin
            st <= S_HUNT;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R4
  ack_code_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACK) |-> ($countones(ack_q) == 1));

  // R8
  perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_perr |=> wr_perr);

endmodule

// File: rtl/swd_tgt_drive.sv
module swd_tgt_drive
  import swd_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fall,
  input  swd_state_e st,
  input  logic [1:0] ack_sel,
  input  logic       data_last,
  input  logic [2:0] ack_q,
  input  logic       rd_bit,
  input  logic       rd_par,
  output logic       dout,
  output logic       oe
);

  logic bit_nx;
  logic oe_nx;

  always_comb begin
    bit_nx = 1'b0;
    oe_nx  = 1'b0;
    if (st == S_ACK) begin
      oe_nx = 1'b1;
      unique case (ack_sel)
        2'd0:    bit_nx = ack_q[0];
        2'd1:    bit_nx = ack_q[1];
        default: bit_nx = ack_q[2];
      endcase
    end else if (st == S_RD) begin
      oe_nx  = 1'b1;
      bit_nx = data_last ? rd_par : rd_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      dout <= 1'b0;
    end else if (fall) begin
      oe   <= oe_nx;
      dout <= bit_nx;
    end
  end

  // R10
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (oe != $past(oe)) |-> $past(fall));

endmodule

// File: rtl/swd_target_responder.sv
module swd_target_responder
  import swd_tgt_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swclk,
  input  logic          swdio_in,
  output logic          swdio_out,
  output logic          swdio_oe,
  output logic          cmd_valid,
  output logic          cmd_ap,
  output logic          cmd_rnw,
  output logic [1:0]    cmd_addr,
  input  logic          resp_valid,
  input  logic [2:0]    resp_ack,
  input  logic [DW-1:0] resp_rdata,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          wr_perr
);

  logic       rise;
  logic       fall;
  logic       din;
  swd_state_e st;
  logic [1:0] ack_sel;
  logic       data_last;
  logic [2:0] ack_q;
  logic       rd_bit;
  logic       rd_par;

  swd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .line_clk (swclk),
    .line_dat (swdio_in),
    .rise     (rise),
    .fall     (fall),
    .dat      (din)
  );

  swd_tgt_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .din        (din),
    .resp_valid (resp_valid),
    .resp_ack   (resp_ack),
    .resp_rdata (resp_rdata),
    .st         (st),
    .ack_sel    (ack_sel),
    .data_last  (data_last),
    .ack_q      (ack_q),
    .rd_bit     (rd_bit),
    .rd_par     (rd_par),
    .cmd_valid  (cmd_valid),
    .cmd_ap     (cmd_ap),
    .cmd_rnw    (cmd_rnw),
    .cmd_addr   (cmd_addr),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_perr    (wr_perr)
  );

  swd_tgt_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .st        (st),
    .ack_sel   (ack_sel),
    .data_last (data_last),
    .ack_q     (ack_q),
    .rd_bit    (rd_bit),
    .rd_par    (rd_par),
    .dout      (swdio_out),
    .oe        (swdio_oe)
  );

endmodule

// File: tb/sim_swd_target_responder.sv
module sim_swd_target_responder;

  localparam time CLK_PERIOD = 10ns;
  localparam time HALF       = CLK_PERIOD * 8;
  localparam logic [2:0] K_OK = 3'b001, K_WAIT = 3'b010, K_FAULT = 3'b100;

  typedef struct packed {
    logic        ap;
    logic        rnw;
    logic [1:0]  addr;
    logic [2:0]  ack;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 2'd0, 3'b001, 32'h1234_5678},
    '{1'b1, 1'b0, 2'd1, 3'b001, 32'hA5A5_0F0F},
    '{1'b1, 1'b1, 2'd3, 3'b001, 32'hFFFF_FFFF},
    '{1'b0, 1'b0, 2'd2, 3'b010, 32'h0000_0000},
    '{1'b1, 1'b1, 2'd2, 3'b100, 32'h0BAD_F00D},
    '{1'b0, 1'b0, 2'd3, 3'b001, 32'h8000_0001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        swclk = 1'b0;
  logic        host_oe = 1'b0;
  logic        host_d = 1'b0;
  logic        resp_valid = 1'b0;
  logic [2:0]  resp_ack = 3'b000;
  logic [31:0] resp_rdata = '0;
  logic        bus_line;
  logic        swdio_out, swdio_oe;
  logic        cmd_valid, cmd_ap, cmd_rnw;
  logic [1:0]  cmd_addr;
  logic        wr_valid, wr_perr;
  logic [31:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int cmd_cnt = 0;
  int wr_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pull-up when nobody drives
  assign bus_line = swdio_oe ? swdio_out : (host_oe ? host_d : 1'b1);

  swd_target_responder u0 (
    .clk        (clk),
    .rst        (rst),
    .swclk      (swclk),
    .swdio_in   (bus_line),
    .swdio_out  (swdio_out),
    .swdio_oe   (swdio_oe),
    .cmd_valid  (cmd_valid),
    .cmd_ap     (cmd_ap),
    .cmd_rnw    (cmd_rnw),
    .cmd_addr   (cmd_addr),
    .resp_valid (resp_valid),
    .resp_ack   (resp_ack),
    .resp_rdata (resp_rdata),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_perr    (wr_perr)
  );

  always @(posedge clk) begin
    if (cmd_valid) cmd_cnt <= cmd_cnt + 1;
    if (wr_valid)  wr_cnt  <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one serial bit: set data after fall, sample just before rise
  task automatic tick(input logic hen, input logic hv, output logic seen, output logic oe_seen);
    host_oe = hen;
    host_d  = hv;
    #(HALF);
    seen    = bus_line;
    oe_seen = swdio_oe;
    swclk = 1'b1;
    #(HALF);
    swclk = 1'b0;
  endtask

  task automatic send_req(input logic ap, input logic rnw, input logic [1:0] addr,
                          input logic flip, input logic stop_v, input logic park_v,
                          output logic drove);
    logic [7:0] b;
    logic s, o;
    b = {park_v, stop_v, (^{ap, rnw, addr}) ^ flip, addr[1], addr[0], rnw, ap, 1'b1};
    drove = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 7 && park_v) tick(1'b0, 1'b0, s, o);
      else                  tick(1'b1, b[i], s, o);
      drove |= o;
    end
    host_oe = 1'b0;
  endtask

  task automatic run_txn(input logic ap, input logic rnw, input logic [1:0] addr,
                         input bit respond, input logic [2:0] rack, input logic [31:0] data,
                         input bit bad_wpar, input logic [2:0] exp_ack, input string tag);
    int c0, w0;
    logic drv, s, o, oe_all, oe_any;
    logic [2:0]  got_ack;
    logic [32:0] got_rd;
    c0 = cmd_cnt;
    w0 = wr_cnt;
    send_req(ap, rnw, addr, 1'b0, 1'b0, 1'b1, drv);
    chk(!drv, "R10 line free during header", drv, 0);
    chk(cmd_cnt == c0 + 1, "R2 one command pulse", cmd_cnt - c0, 1);
    chk({cmd_ap, cmd_rnw, cmd_addr} == {ap, rnw, addr}, "R2 decoded fields",
        {cmd_ap, cmd_rnw, cmd_addr}, {ap, rnw, addr});
    // turnaround bit, agent answers early in it
    host_oe = 1'b0;
    if (respond) begin
      resp_ack = rack;
      resp_rdata = data;
      resp_valid = 1'b1;
      #(CLK_PERIOD);
      resp_valid = 1'b0;
      #(HALF - CLK_PERIOD);
    end else begin
      #(HALF);
    end
    chk(!swdio_oe, "R4 turnaround after header undriven", swdio_oe, 0);
    swclk = 1'b1;
    #(HALF);
    swclk = 1'b0;
    oe_all = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, s, o);
      got_ack[i] = s;
      oe_all &= o;
    end
    chk(got_ack == exp_ack, tag, got_ack, exp_ack);
    chk(oe_all, "R10 enable high during acknowledge", oe_all, 1);
    if (exp_ack == K_OK && rnw) begin
      oe_all = 1'b1;
      for (int i = 0; i < 33; i++) begin
        tick(1'b0, 1'b0, s, o);
        got_rd[i] = s;
        oe_all &= o;
      end
      chk(got_rd[31:0] == data, "R6 read word", got_rd[31:0], data);
      chk(got_rd[32] == ^data, "R6 read parity", got_rd[32], ^data);
      chk(oe_all, "R10 enable high during read data", oe_all, 1);
      tick(1'b0, 1'b0, s, o);
      chk(!o, "R6 trailing turnaround released", o, 0);
    end else begin
      tick(1'b0, 1'b0, s, o);
      chk(!o, "R9 line released after acknowledge", o, 0);
      if (exp_ack == K_OK) begin
        oe_any = 1'b0;
        for (int i = 0; i < 33; i++) begin
          tick(1'b1, (i < 32) ? data[i] : ((^data) ^ bad_wpar), s, o);
          oe_any |= o;
        end
        host_oe = 1'b0;
        chk(!oe_any, "R10 target silent in write phase", oe_any, 0);
        #(CLK_PERIOD * 4);
        if (bad_wpar) begin
          chk(wr_cnt == w0, "R8 bad-parity write discarded", wr_cnt - w0, 0);
          chk(wr_perr, "R8 parity error flag set", wr_perr, 1);
        end else begin
          chk(wr_cnt == w0 + 1, "R7 one write pulse", wr_cnt - w0, 1);
          chk(wr_data == data, "R7 write word", wr_data, data);
        end
      end else begin
        chk(wr_cnt == w0, "R9 no data phase after WAIT or FAULT", wr_cnt - w0, 0);
      end
    end
  endtask

  task automatic bad_req(input logic flip, input logic stop_v, input logic park_v, input string tag);
    int c0;
    logic drv;
    c0 = cmd_cnt;
    send_req(1'b1, 1'b1, 2'd1, flip, stop_v, park_v, drv);
    #(CLK_PERIOD * 4);
    chk(cmd_cnt == c0, tag, cmd_cnt - c0, 0);
    chk(!drv && !swdio_oe, "R3 line left undriven", drv | swdio_oe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    #(CLK_PERIOD * 5);
    chk({swdio_oe, cmd_valid, wr_valid, wr_perr} == 4'b0, "R1 outputs in reset",
        {swdio_oe, cmd_valid, wr_valid, wr_perr}, 0);
    rst = 1'b0;
    #(CLK_PERIOD * 3);
    chk({swdio_oe, cmd_valid, wr_valid, wr_perr} == 4'b0, "R1 outputs after reset",
        {swdio_oe, cmd_valid, wr_valid, wr_perr}, 0);

    // vector table: R2 R4 R6 R7 R9
    for (int v = 0; v < 6; v++) begin
      run_txn(VECS[v].ap, VECS[v].rnw, VECS[v].addr, 1'b1, VECS[v].ack, VECS[v].data,
              1'b0, VECS[v].ack, "R4 acknowledge bits");
    end

    // R3 malformed headers, each followed by a good one
    bad_req(1'b1, 1'b0, 1'b1, "R3 bad parity rejected");
    run_txn(1'b0, 1'b1, 2'd1, 1'b1, K_OK, 32'hCAFE_0001, 1'b0, K_OK, "R3 recovery after parity");
    bad_req(1'b0, 1'b1, 1'b1, "R3 stop bit 1 rejected");
    run_txn(1'b1, 1'b0, 2'd0, 1'b1, K_OK, 32'h0000_FFFF, 1'b0, K_OK, "R3 recovery after stop");
    bad_req(1'b0, 1'b0, 1'b0, "R3 park bit 0 rejected");
    run_txn(1'b0, 1'b1, 2'd3, 1'b1, K_OK, 32'h7654_3210, 1'b0, K_OK, "R3 recovery after park");

    // R5 no answer -> WAIT, stale answer ignored, illegal codes -> FAULT
    run_txn(1'b0, 1'b1, 2'd0, 1'b0, K_OK, 32'h0, 1'b0, K_WAIT, "R5 no response gives WAIT");
    resp_ack = K_OK;
    resp_valid = 1'b1;
    #(CLK_PERIOD);
    resp_valid = 1'b0;
    run_txn(1'b1, 1'b1, 2'd1, 1'b0, K_OK, 32'h0, 1'b0, K_WAIT, "R5 early response ignored");
    run_txn(1'b0, 1'b0, 2'd2, 1'b1, 3'b011, 32'h0, 1'b0, K_FAULT, "R5 illegal code 011 as FAULT");
    run_txn(1'b1, 1'b1, 2'd3, 1'b1, 3'b000, 32'h0, 1'b0, K_FAULT, "R5 illegal code 000 as FAULT");

    // R8 bad write parity, then a good write still lands and the flag stays
    chk(!wr_perr, "R8 flag clear before error", wr_perr, 0);
    run_txn(1'b1, 1'b0, 2'd2, 1'b1, K_OK, 32'h1357_9BDF, 1'b1, K_OK, "R4 acknowledge bits");
    run_txn(1'b0, 1'b0, 2'd1, 1'b1, K_OK, 32'h2468_ACE0, 1'b0, K_OK, "R4 acknowledge bits");
    chk(wr_perr, "R8 flag stays set", wr_perr, 1);

    // R1 reset clears the sticky flag
    rst = 1'b1;
    #(CLK_PERIOD * 3);
    rst = 1'b0;
    #(CLK_PERIOD * 2);
    chk(!wr_perr && !swdio_oe, "R1 reset clears error flag", {wr_perr, swdio_oe}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule